// File: doc/BRIEF.md
# Ring Signal Cadence Detector

This block decides whether a telephone line is carrying a genuine ringing signal. It takes a one-bit ring-sense input from the line interface and passes it through a synchroniser. It then measures the time between successive rising edges in ticks of a free-running reference enable. With a 144 kHz tick, a ringing frequency F gives a count of 144000 / F. The default window therefore runs from 0x0809, which is 70 Hz, up to 0x282D, which is 14 Hz. Both bounds are inclusive.

Each measured cycle is either accepted or rejected. An accepted cycle adds to a count of consecutive good cycles. The ring-present flag rises once that count reaches a programmable minimum, which defaults to 2, and stays high while good cycles continue. A cycle outside the window produces a one-cycle error pulse, clears the count and drops the flag. If no edge arrives before the period counter saturates, the detector treats ringing as over. It clears its state and re-arms, so the next edge only starts a new measurement.

Top module: `ring_cadence_det`

## Requirements
- R1: While reset is held and in the first cycle after it, ring_present and period_err are both 0.
- R2: The period is the number of clock edges with tick_en = 1 in the interval after one processed rising edge of the synchronised input, up to and including the next one. Edges with tick_en = 0 do not count.
- R3: A period p is accepted exactly when period_min <= p <= period_max, with both bounds inclusive.
- R4: The first rising edge after reset, or after a timeout, only starts a measurement. It changes neither output.
- R5: A period outside the window makes period_err 1 for exactly one clock cycle. It also clears the consecutive-valid count and sets ring_present to 0.
- R6: ring_present goes to 1 on the accepted cycle that brings the consecutive-valid count to cycles_min. It keeps its value while no edge is processed and no timeout occurs.
- R7: If the period counter reaches 2^CNT_W-1 ticks with no edge, ring_present goes to 0, the count clears and the detector re-arms. The next edge then raises no error.
- R8: Both outputs are registered. They change on the third rising clock edge that samples ring_sense high after it was low: two synchroniser stages, then one output register.
- R9: period_err and ring_present are never 1 in the same cycle.
- R10: The consecutive-valid count saturates at 2^CYC_W-1 and does not wrap. With cycles_min = 255, ring_present therefore stays 1 across any run of more than 255 valid cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick enable (nominally 144 kHz) |
| ring_sense | input | 1 | Asynchronous digitised ring-sense bit |
| period_min | input | 16 | Lowest accepted period count (highest frequency) |
| period_max | input | 16 | Highest accepted period count (lowest frequency) |
| cycles_min | input | 8 | Consecutive valid cycles needed for ringing |
| ring_present | output | 1 | Ringing detected |
| period_err | output | 1 | One-cycle pulse on an out-of-window period |

## Verification
The assertions check on every cycle the invariants that do not depend on timing:
- the error pulse is one cycle wide and never coincides with ring_present;
- ring_present holds its value when no edge is processed and no timeout occurs;
- a timeout forces ring_present low;
- the period counter restarts after every edge.

Some behaviour can only be shown by the bench scenarios, because it depends on particular periods and patterns. These are:
- the inclusive window bounds;
- the tick-gated period count under a sparse tick;
- the arming edge;
- the exact output latency;
- the count of valid cycles needed before ringing;
- counter saturation over long runs;
- the long timeout.

// File: rtl/ring_cad_pkg.sv
package ring_cad_pkg;

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_LIVE = 1'b1
    } arm_e;

    typedef struct packed {
        logic ok;
        logic bad;
    } verdict_t;

    function automatic verdict_t judge_period(input logic [31:0] val,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        verdict_t v;
        v.ok  = (val >= lo) && (val <= hi);
        v.bad = !v.ok;
        return v;
    endfunction

    function automatic logic [31:0] sat_inc(input logic [31:0] val,
                                            input logic [31:0] top);
        return (val >= top) ? top : val + 32'd1;
    endfunction

endpackage

// File: rtl/rcd_sync_edge.sv
module rcd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], din};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/rcd_period_meter.sv
module rcd_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_en,
    input  logic           rise,
    output logic [CNT_W:0] meas,
    output logic           timeout
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    assign meas    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick_en};
    assign timeout = (cnt_q == CNT_TOP) && !rise;

    always_ff @(posedge clk) begin
        if (rst)                             cnt_q <= '0;
        else if (rise)                       cnt_q <= '0;
        else if (tick_en && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_restart_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> (cnt_q == '0));
endmodule

// File: rtl/rcd_cycle_judge.sv
module rcd_cycle_judge #(
    parameter int CNT_W = 16,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             timeout,
    input  logic [CNT_W:0]   meas,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [CYC_W-1:0] need,
    output logic             ring_o,
    output logic             err_o
);
    import ring_cad_pkg::*;

    localparam logic [31:0] VCNT_TOP = 32'((64'd1 << CYC_W) - 1);

    arm_e             arm_q;
    logic [CYC_W-1:0] vcnt_q;
    logic [CYC_W-1:0] vnext;
    verdict_t         vd;

    assign vd    = judge_period(32'(meas), 32'(lim_lo), 32'(lim_hi));
    assign vnext = CYC_W'(sat_inc(32'(vcnt_q), VCNT_TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= ARM_WAIT;
            vcnt_q <= '0;
            ring_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            err_o <= 1'b0;
            if (timeout) begin
                arm_q  <= ARM_WAIT;
                vcnt_q <= '0;
                ring_o <= 1'b0;
            end else if (rise) begin
                if (arm_q == ARM_WAIT) begin
                    arm_q <= ARM_LIVE;
                end else if (vd.ok) begin
                    vcnt_q <= vnext;
                    ring_o <= (vnext >= need);
                end else begin
                    vcnt_q <= '0;
                    ring_o <= 1'b0;
                    err_o  <= 1'b1;
                end
            end
        end
    end

    p_ring_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !(rise || timeout) |=> $stable(ring_o));
    p_err_clears_count_r5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (vcnt_q == '0));
endmodule

// File: rtl/ring_cadence_det.sv
module ring_cadence_det #(
    parameter int CNT_W       = 16,
    parameter int CYC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             ring_sense,
    input  logic [CNT_W-1:0] period_min,
    input  logic [CNT_W-1:0] period_max,
    input  logic [CYC_W-1:0] cycles_min,
    output logic             ring_present,
    output logic             period_err
);
    logic           rise;
    logic           timeout;
    logic [CNT_W:0] meas;

    rcd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (ring_sense),
        .rise(rise)
    );

    rcd_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .rise   (rise),
        .meas   (meas),
        .timeout(timeout)
    );

    rcd_cycle_judge #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_judge (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .timeout(timeout),
        .meas   (meas),
        .lim_lo (period_min),
        .lim_hi (period_max),
        .need   (cycles_min),
        .ring_o (ring_present),
        .err_o  (period_err)
    );

    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        period_err |-> !ring_present);
    p_err_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        period_err |=> !period_err);
    p_timeout_drop_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !ring_present);
endmodule

// File: tb/ring_cadence_det_test.sv
`timescale 1ns/1ps
module ring_cadence_det_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        ring_sense = 1'b0;
    logic [15:0] period_min = 16'h0809;
    logic [15:0] period_max = 16'h282D;
    logic [7:0]  cycles_min = 8'd2;
    logic        ring_present;
    logic        period_err;

    int checks = 0;
    int failures = 0;
    bit tick_alt = 1'b0;
    bit done = 1'b0;

    bit m_arm;
    int m_vcnt;
    bit m_ring;
    bit m_err;
    int prev_p;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (tick_alt) tick_en <= ~tick_en;
        else          tick_en <= 1'b1;
    end

    ring_cadence_det uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ring_sense(ring_sense),
        .period_min(period_min), .period_max(period_max), .cycles_min(cycles_min),
        .ring_present(ring_present), .period_err(period_err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_arm = 0; m_vcnt = 0; m_ring = 0; m_err = 0; prev_p = 0;
    endtask

    task automatic model_step(input int t);
        if (!m_arm) begin
            m_arm = 1; m_err = 0;
        end else if (t >= int'(period_min) && t <= int'(period_max)) begin
            m_vcnt = (m_vcnt >= 255) ? 255 : m_vcnt + 1;
            m_ring = (m_vcnt >= int'(cycles_min));
            m_err  = 0;
        end else begin
            m_vcnt = 0; m_ring = 0; m_err = 1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ring_sense = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 ring in reset", ring_present, 1'b0);
        check("R1 err in reset", period_err, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ring after reset", ring_present, 1'b0);
        check("R1 err after reset", period_err, 1'b0);
        model_reset();
    endtask

    // Raise ring_sense now, check the verdict on the previous period, then hold for p cycles.
    task automatic do_rise(input int p, input string tag);
        int ticks;
        ticks = tick_alt ? prev_p / 2 : prev_p;
        ring_sense = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check({"R8 early err ", tag}, period_err, 1'b0);
        @(negedge clk);
        model_step(ticks);
        check({tag, " ring"}, ring_present, m_ring);
        check({tag, " err"}, period_err, m_err);
        if (period_err) check("R9 exclusive", ring_present, 1'b0);
        @(negedge clk);
        check("R5 err width", period_err, 1'b0);
        for (int i = 4; i < p; i++) begin
            if (i == p / 2) ring_sense = 1'b0;
            @(negedge clk);
        end
        prev_p = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        check("R1 default lo", period_min == 16'h0809, 1'b1);

        // Directed window edges, arming and ring qualification
        period_min = 16'd30; period_max = 16'd60; cycles_min = 8'd2;
        do_reset();
        do_rise(40, "R4");
        do_rise(40, "R4");
        do_rise(40, "R6");
        do_rise(30, "R6");
        do_rise(60, "R3");
        do_rise(61, "R3");
        do_rise(40, "R5");
        do_rise(29, "R3");
        do_rise(40, "R5");
        do_rise(40, "R6");

        // Sparse tick: every other clock edge counts
        period_min = 16'd20; period_max = 16'd30; cycles_min = 8'd1;
        do_reset();
        tick_alt = 1'b1;
        do_rise(50, "R2");
        do_rise(50, "R2");
        do_rise(70, "R2");
        do_rise(50, "R2");
        do_rise(60, "R2");
        do_rise(50, "R2");
        tick_alt = 1'b0;
        @(negedge clk);

        // Random periods around the window
        period_min = 16'd30; period_max = 16'd60; cycles_min = 8'd3;
        do_reset();
        for (int k = 0; k < 60; k++) begin
            do_rise(24 + int'($urandom % 43), "R3");
        end

        // Count saturation
        period_min = 16'd10; period_max = 16'd20; cycles_min = 8'd255;
        do_reset();
        for (int k = 0; k < 300; k++) begin
            do_rise(15, "R10");
        end
        check("R10 ring after long run", ring_present, 1'b1);

        // Timeout with no edges
        repeat (60000) @(negedge clk);
        check("R7 not early", ring_present, 1'b1);
        repeat (5600) @(negedge clk);
        check("R7 ring dropped", ring_present, 1'b0);
        m_arm = 0; m_vcnt = 0; m_ring = 0;
        do_rise(15, "R7");
        do_rise(15, "R7");
        do_rise(15, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule